// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog counter whose configuration and service are guarded by fixed 16-bit key pairs. Software talks to it through one synchronous write port with five register addresses: a key register, two control registers, a timeout limit and a refresh window limit. The counter advances on a separate clock-enable input (`tick`). It keeps running while the processor is halted or single-stepping, so a key pair written too slowly fails.

A refresh pair restarts the count. An unlock pair opens a bounded period during which configuration writes are accepted. Each of the following raises the single reset request output:

- a bad key word;
- a key pair whose halves are too far apart;
- a configuration write while the period is closed;
- an early refresh in windowed mode;
- a timeout.

The chip's reset logic consumes that output.

Top module: `wdg_keyed_top`

## Requirements
- R1: Out of reset, `count` is 0 and `reset_req` is 0. The control word is 0x01 (enabled) and the timeout limit is TOV_RST. Configuration writes are accepted for CFG_CYC clock edges after reset is released.
- R2: Writing 0xC520 and then 0xD928 to address 0 unlocks. The configuration period then reopens for CFG_CYC edges, counted from the edge that takes the second word. Writes to address 1 (control, bits 7:0), address 2 (bit 0 = windowed mode), address 3 (timeout limit) and address 4 (window limit) are stored while it is open.
- R3: A write to addresses 1 to 4 while the configuration period is closed raises `reset_req` at the edge that takes the write. Writes to addresses 5 to 7 have no effect.
- R4: Writing 0xA602 and then 0xB480 to address 0 is a refresh. The edge that takes 0xB480 sets `count` to 0.
- R5: Any of the following key writes raises `reset_req` at the edge that takes it and returns the key logic to idle:
  - a first word other than 0xC520 or 0xA602;
  - a second word that does not match its first word;
  - a lone second word.
- R6: The second key word must arrive within KEY_GAP (16) edges of the first. If it has not arrived, `reset_req` rises KEY_GAP edges after the first word.
- R7: While enabled, `count` rises by one at each edge where `tick` is 1. It holds when `tick` is 0.
- R8: While enabled, a `count` equal to the timeout limit raises `reset_req` at the next edge. The same edge sets `count` to 0.
- R9: A control word of 0 disables the block. `count` stays 0 and no timeout or window violation occurs; key checking stays active.
- R10: With windowed mode set and a nonzero window limit, a refresh completed while `count` is below the window limit raises `reset_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Counter clock enable |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Register address (0 key, 1 control, 2 mode, 3 timeout, 4 window) |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value |
| reset_req | output | 1 | Registered reset request, high for each cycle an event occurred |

## Verification
The assertions assume the following about the inputs:
- Writes arrive one per clock with a stable address and data.
- `tick` is an ordinary level that the bench may hold at 0 to freeze the count.
- The window reload length is nonzero.

The stimulus drives `wr_en`, `wr_addr`, `wr_data` and `tick` only at falling edges, so every write is taken at exactly one rising edge. It keeps `tick` low outside the counting tests, which stops stray timeouts and lets each expected reset pulse be predicted to the exact edge.

// File: rtl/wdg_pkg.sv
// Shared constants and types for the keyed watchdog.
// Assumes a 16-bit register word; key values are fixed by the service protocol.
package wdg_pkg;
    localparam int WORD_W = 16;

    localparam logic [WORD_W-1:0] K_UNLK_A = 16'hC520;
    localparam logic [WORD_W-1:0] K_UNLK_B = 16'hD928;
    localparam logic [WORD_W-1:0] K_RFSH_A = 16'hA602;
    localparam logic [WORD_W-1:0] K_RFSH_B = 16'hB480;

    localparam logic [2:0] RA_KEY  = 3'd0;
    localparam logic [2:0] RA_CTLA = 3'd1;
    localparam logic [2:0] RA_CTLB = 3'd2;
    localparam logic [2:0] RA_TOV  = 3'd3;
    localparam logic [2:0] RA_WIN  = 3'd4;

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_UNLK,
        KS_RFSH
    } kstate_t;
endpackage

// File: rtl/wdg_keyseq.sv
// Key-pair checker. Recognises the unlock and refresh pairs written to the key
// register, enforces the inter-word gap and flags any stray or late word.
// Assumes at most one key write per cycle; outputs are single-cycle pulses.
module wdg_keyseq
    import wdg_pkg::*;
#(
    parameter int KEY_GAP = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [WORD_W-1:0] key_data,
    output logic              unlock_p,
    output logic              refresh_p,
    output logic              key_bad
);
    localparam int GW = (KEY_GAP > 1) ? $clog2(KEY_GAP) : 1;
    localparam logic [GW-1:0] GAP_LAST = GW'(KEY_GAP - 1);

    kstate_t         st, nxt;
    logic [GW-1:0]   gap;

    // Decode the next key state and the pulses for this cycle.
    always_comb begin
        nxt       = st;
        unlock_p  = 1'b0;
        refresh_p = 1'b0;
        key_bad   = 1'b0;
        case (st)
            KS_IDLE: begin
                if (key_wr) begin
                    if (key_data == K_UNLK_A)      nxt = KS_UNLK;
                    else if (key_data == K_RFSH_A) nxt = KS_RFSH;
                    else                           key_bad = 1'b1;
                end
            end
            KS_UNLK: begin
                if (key_wr) begin
                    nxt = KS_IDLE;
                    if (key_data == K_UNLK_B) unlock_p = 1'b1;
                    else                      key_bad  = 1'b1;
                end else if (gap == GAP_LAST) begin
                    nxt     = KS_IDLE;
                    key_bad = 1'b1;
                end
            end
            KS_RFSH: begin
                if (key_wr) begin
                    nxt = KS_IDLE;
                    if (key_data == K_RFSH_B) refresh_p = 1'b1;
                    else                      key_bad   = 1'b1;
                end else if (gap == GAP_LAST) begin
                    nxt     = KS_IDLE;
                    key_bad = 1'b1;
                end
            end
            default: nxt = KS_IDLE;
        endcase
    end

    // Hold the key state and count cycles spent waiting for a second word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= KS_IDLE;
            gap <= '0;
        end else begin
            st  <= nxt;
            gap <= (st == KS_IDLE) ? '0 : gap + 1'b1;
        end
    end
endmodule

// File: rtl/wdg_cfgwin.sv
// Configuration period and registers. The period is open after reset and
// after each unlock for CFG_CYC edges; writes outside it are violations.
// Assumes cfg_wr is asserted only for addresses 1..4.
module wdg_cfgwin
    import wdg_pkg::*;
#(
    parameter int              CFG_CYC = 128,
    parameter logic [WORD_W-1:0] TOV_RST = 16'd1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_addr,
    input  logic [WORD_W-1:0] cfg_data,
    input  logic              unlock_p,
    output logic              cfg_open,
    output logic              cfg_bad,
    output logic [7:0]        ctl_a,
    output logic              win_chk,
    output logic [WORD_W-1:0] tov,
    output logic [WORD_W-1:0] win
);
    localparam int WW = $clog2(CFG_CYC + 1);
    localparam logic [WW-1:0] WLOAD = WW'(CFG_CYC);

    logic [WW-1:0] wcnt;

    assign cfg_open = (wcnt != '0);
    assign cfg_bad  = cfg_wr && !cfg_open;

    // Reload the period on unlock, otherwise let it run down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          wcnt <= WLOAD;
        else if (unlock_p)   wcnt <= WLOAD;
        else if (cfg_open)   wcnt <= wcnt - 1'b1;
    end

    // Store configuration writes that land inside the open period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_a   <= 8'h01;
            win_chk <= 1'b0;
            tov     <= TOV_RST;
            win     <= '0;
        end else if (cfg_wr && cfg_open) begin
            case (cfg_addr)
                RA_CTLA: ctl_a   <= cfg_data[7:0];
                RA_CTLB: win_chk <= cfg_data[0];
                RA_TOV:  tov     <= cfg_data;
                RA_WIN:  win     <= cfg_data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/wdg_counter.sv
// Timeout counter with window compare. Counts on tick while enabled, clears on
// refresh or timeout, and flags a refresh that comes before the window limit.
// Assumes tov/win are stable register outputs.
module wdg_counter
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic              win_chk,
    input  logic [WORD_W-1:0] tov,
    input  logic [WORD_W-1:0] win,
    input  logic              refresh_p,
    output logic [WORD_W-1:0] cnt,
    output logic              timeout,
    output logic              win_bad
);
    assign timeout = en && (cnt == tov);
    assign win_bad = en && refresh_p && win_chk && (win != '0) && (cnt < win);

    // Advance, clear or hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n)                             cnt <= '0;
        else if (!en || refresh_p || timeout)   cnt <= '0;
        else if (tick)                          cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/wdg_keyed_top.sv
// Keyed watchdog top. Decodes the write port, joins key checking, the
// configuration period and the counter, and registers the reset request.
// Assumes a single synchronous writer and tick synchronous to clk.
module wdg_keyed_top
    import wdg_pkg::*;
#(
    parameter int                KEY_GAP = 16,
    parameter int                CFG_CYC = 128,
    parameter logic [WORD_W-1:0] TOV_RST = 16'd1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [15:0]       wr_data,
    output logic [15:0]       count,
    output logic              reset_req
);
    logic              key_wr, cfg_wr;
    logic              unlock_p, refresh_p, key_bad;
    logic              cfg_open, cfg_bad;
    logic [7:0]        ctl_a;
    logic              win_chk, en;
    logic [WORD_W-1:0] tov, win;
    logic              timeout, win_bad;

    assign key_wr = wr_en && (wr_addr == RA_KEY);
    assign cfg_wr = wr_en && (wr_addr >= RA_CTLA) && (wr_addr <= RA_WIN);
    assign en     = (ctl_a != 8'h00);

    wdg_keyseq #(.KEY_GAP(KEY_GAP)) u_key (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(wr_data),
        .unlock_p(unlock_p), .refresh_p(refresh_p), .key_bad(key_bad)
    );

    wdg_cfgwin #(.CFG_CYC(CFG_CYC), .TOV_RST(TOV_RST)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(wr_addr),
        .cfg_data(wr_data), .unlock_p(unlock_p), .cfg_open(cfg_open),
        .cfg_bad(cfg_bad), .ctl_a(ctl_a), .win_chk(win_chk), .tov(tov), .win(win)
    );

    wdg_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .win_chk(win_chk),
        .tov(tov), .win(win), .refresh_p(refresh_p), .cnt(count),
        .timeout(timeout), .win_bad(win_bad)
    );

    // Register any violation or timeout into the reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) reset_req <= 1'b0;
        else        reset_req <= key_bad || cfg_bad || timeout || win_bad;
    end
endmodule

// File: rtl/wdg_checker.sv
// Temporal checks for the keyed watchdog, bound into the top module.
// Assumes the internal pulse names of wdg_keyed_top.
module wdg_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        en,
    input logic [15:0] count,
    input logic [15:0] tov,
    input logic        refresh_p,
    input logic        unlock_p,
    input logic        key_bad,
    input logic        cfg_wr,
    input logic        cfg_open,
    input logic        reset_req
);
    a_r2_unlock_opens: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_p |=> cfg_open);

    a_r3_closed_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_open) |=> reset_req);

    a_r4_refresh_clears: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_p |=> (count == 16'd0));

    a_r5_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
        key_bad |=> reset_req);

    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && !refresh_p && (count != tov)) |=> (count == $past(count) + 16'd1));

    a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick && !refresh_p && (count != tov)) |=> $stable(count));

    a_r8_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (count == tov)) |=> (reset_req && (count == 16'd0)));

    a_r9_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (count == 16'd0));
endmodule

bind wdg_keyed_top wdg_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .count(count), .tov(tov),
    .refresh_p(refresh_p), .unlock_p(unlock_p), .key_bad(key_bad),
    .cfg_wr(cfg_wr), .cfg_open(cfg_open), .reset_req(reset_req)
);

// File: tb/sim_wdg_keyed_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected reset pulses and counts,
// a negedge monitor compares them against the outputs every cycle.
module sim_wdg_keyed_top;
    logic        clk = 1'b0;
    logic        rst_n, tick, wr_en;
    logic [2:0]  wr_addr;
    logic [15:0] wr_data;
    logic [15:0] count;
    logic        reset_req;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit run = 0;
    bit done = 0;

    typedef struct { int at; int val; string tag; } exp_t;
    exp_t req_q[$];
    exp_t cnt_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdg_keyed_top u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .count(count), .reset_req(reset_req)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic push_req(input int at, input string tag);
        exp_t e; e.at = at; e.val = 1; e.tag = tag; req_q.push_back(e);
    endtask

    task automatic push_cnt(input int at, input int val, input string tag);
        exp_t e; e.at = at; e.val = val; e.tag = tag; cnt_q.push_back(e);
    endtask

    // Monitor: compare reset_req and queued counts at each falling edge.
    always @(negedge clk) begin
        if (run) begin
            while (cnt_q.size() > 0 && cnt_q[0].at == cyc) begin
                check(count == cnt_q[0].val[15:0], cnt_q[0].tag, count, cnt_q[0].val);
                void'(cnt_q.pop_front());
            end
            if (req_q.size() > 0 && req_q[0].at == cyc) begin
                check(reset_req == 1'b1, req_q[0].tag, reset_req, 1);
                void'(req_q.pop_front());
            end else if (reset_req) begin
                check(1'b0, "unexpected reset_req", 1, 0);
            end
        end
    end

    // Driver: one write taken at the next rising edge; called at a falling edge.
    task automatic wr(input logic [2:0] a, input logic [15:0] d,
                      input bit bad, input string tag, output int w);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        w = cyc + 1;
        if (bad) push_req(w, tag);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Raise tick for n edges and expect the count to reach final_val.
    task automatic tick_n(input int n, input int final_val, input string tag);
        int s;
        tick = 1'b1;
        s = cyc + 1;
        push_cnt(s + n, final_val, tag);
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic refresh(input bit bad, input string tag);
        int w;
        wr(3'd0, 16'hA602, 1'b0, tag, w);
        wr(3'd0, 16'hB480, bad, tag, w);
        push_cnt(w + 1, 0, tag);
    endtask

    task automatic unlock(input string tag);
        int w;
        wr(3'd0, 16'hC520, 1'b0, tag, w);
        wr(3'd0, 16'hD928, 1'b0, tag, w);
    endtask

    initial begin
        int w;
        rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        check(count == 16'd0, "R1 count in reset", count, 0);
        check(reset_req == 1'b0, "R1 reset_req in reset", reset_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(count == 16'd0, "R1 count after reset", count, 0);
        run = 1;

        // R1: initial configuration period accepts writes
        wr(3'd3, 16'd30, 1'b0, "R1", w);
        wr(3'd2, 16'd0, 1'b0, "R1", w);

        // R7 counting, then R4 refresh clears
        tick_n(10, 10, "R7 count after 10 ticks");
        idle(2);
        refresh(1'b0, "R4 refresh clears count");
        idle(2);

        // R8 timeout at limit 30
        begin
            int s;
            tick = 1'b1;
            s = cyc + 1;
            push_cnt(s + 14, 15, "R7 mid count");
            push_req(s + 30, "R8 timeout pulse");
            push_cnt(s + 30, 0, "R8 count cleared");
            repeat (31) @(negedge clk);
            tick = 1'b0;
        end
        idle(3);

        // R5 bad keys
        wr(3'd0, 16'h1234, 1'b1, "R5 stray word", w);       idle(2);
        wr(3'd0, 16'hD928, 1'b1, "R5 lone second word", w); idle(2);
        wr(3'd0, 16'h00C5, 1'b1, "R5 partial word", w);     idle(2);
        wr(3'd0, 16'hA602, 1'b0, "R5", w);
        wr(3'd0, 16'hC520, 1'b1, "R5 mixed pair", w);       idle(2);

        // R6 gap expiry
        wr(3'd0, 16'hC520, 1'b0, "R6", w);
        push_req(w + 16, "R6 gap expired");
        idle(20);
        // R6 gap of exactly 16 edges accepted
        wr(3'd0, 16'hC520, 1'b0, "R6", w);
        idle(15);
        wr(3'd0, 16'hD928, 1'b0, "R6 gap 16 accepted", w);
        idle(2);
        // R6 gap of 17: expiry, then lone second word
        wr(3'd0, 16'hA602, 1'b0, "R6", w);
        push_req(w + 16, "R6 gap 17 expired");
        idle(16);
        wr(3'd0, 16'hB480, 1'b1, "R6 late second word", w);
        idle(2);

        // R3 closed period
        idle(140);
        wr(3'd1, 16'h0001, 1'b1, "R3 write while closed", w);
        idle(2);
        wr(3'd5, 16'h0000, 1'b0, "R3 unused address ignored", w);
        tick_n(3, 3, "R3 state unchanged");
        idle(2);

        // R2 unlock and R9 disable
        unlock("R2");
        wr(3'd1, 16'h0000, 1'b0, "R2 write after unlock", w);
        tick_n(40, 0, "R9 disabled count stays 0");
        refresh(1'b0, "R9 refresh while disabled");
        idle(2);

        // R10 window compare
        wr(3'd1, 16'h0001, 1'b0, "R10", w);
        wr(3'd2, 16'h0001, 1'b0, "R10", w);
        wr(3'd4, 16'd10, 1'b0, "R10", w);
        wr(3'd3, 16'd30, 1'b0, "R10", w);
        refresh(1'b1, "R10 early refresh");
        idle(2);
        tick_n(12, 12, "R10 count past window");
        refresh(1'b0, "R10 refresh in window");
        idle(4);

        check(req_q.size() == 0, "pending reset pulses", req_q.size(), 0);
        check(cnt_q.size() == 0, "pending count checks", cnt_q.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule